// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Array

This cell sits behind one OR sum of a programmable AND/OR array and turns that sum into a pin drive value, a pin output enable and a feedback signal back into the array. It holds one D flip-flop, an output select that picks the flip-flop or the raw sum, a polarity stage, and a feedback select that picks the flip-flop state or the pin level. A three-bit configuration word chooses one of six legal modes.

The flip-flop loads the sum on each rising clock edge. A global synchronous preset term forces it to one at the next edge. A global clear term forces it to zero at once, between edges if need be, and wins over the preset. A synchronous active-high power-on reset also clears it. The pad is modelled as a data value plus an enable. Pin feedback reads the externally resolved pin level, so a disabled output turns the pin into a plain input.

Top module: `sop_macrocell`

## Requirements
- R1: With the preset, clear and reset terms low, the flip-flop state after a rising clock edge equals the sum term sampled at that edge.
- R2: When the preset term is high (and the clear term low) at a rising edge, the flip-flop state becomes one.
- R3: When the clear term goes high, the flip-flop state is zero at once, without waiting for a clock edge, and stays zero while it is held.
- R4: When the clear and preset terms are both high at an edge, the flip-flop state is zero.
- R5: With cfg[1]=1 the pin value is taken straight from the sum term (combinational), whatever cfg[2] holds.
- R6: cfg[0]=1 drives the selected value unchanged and cfg[0]=0 drives it inverted; the inversion comes after the registered/combinational select.
- R7: With cfg[2]=0 and cfg[1]=0 the output is registered and fb_out carries the flip-flop state before inversion.
- R8: With cfg[1]=1, or with cfg[2]=1 and cfg[1]=0, fb_out carries pin_in; the last case keeps a registered output.
- R9: pin_oe equals oe_term at all times; with it low, the pin can be read back through fb_out in the pin-feedback modes.
- R10: A high rst at a rising edge clears the flip-flop, so a registered pin then reads one in active-low mode and zero in active-high mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg | input | 3 | Mode word: [2] feedback source when registered, [1] combinational, [0] active-high |
| sum_term | input | 1 | OR sum from the array |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| pin_in | input | 1 | Resolved level seen on the pin |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
A wrong flip-flop state shows on pin_out in every registered mode right after the edge that loaded it, and on fb_out as well in the register-feedback mode, so a lost preset, a slow clear or a reversed priority is seen within one clock. A fault in the select or polarity logic shows without any clock, as a wrong level on pin_out or fb_out as soon as cfg or the sum changes. The mid-cycle clear pulse is checked between edges, where a design that only clears synchronously still holds a one.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int CFG_W = 3;
  localparam int CFG_FBSEL = 2;
  localparam int CFG_COMB  = 1;
  localparam int CFG_POL   = 0;

  typedef struct packed {
    logic comb;      // raw sum goes to the pin
    logic fb_pin;    // feedback taken from the pin level
    logic act_high;  // drive without inversion
  } mode_t;

  function automatic mode_t decode_mode(input logic [CFG_W-1:0] c);
    mode_t m;
    m.comb     = c[CFG_COMB];
    m.fb_pin   = c[CFG_COMB] | c[CFG_FBSEL];
    m.act_high = c[CFG_POL];
    return m;
  endfunction
endpackage

// File: rtl/mcell_cfg_decode.sv
module mcell_cfg_decode
  import mcell_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic [W-1:0] cfg,
  output mode_t        mode
);
  always_comb mode = decode_mode(cfg);

  always_comb begin
    if (cfg[CFG_COMB]) begin
      AST_COMB_PINFB: assert (mode.comb && mode.fb_pin); // R5
    end
  end
endmodule

// File: rtl/mcell_state_reg.sv
module mcell_state_reg #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic preset_term,
  input  logic clear_term,
  output logic q
);
  always_ff @(posedge clk or posedge clear_term) begin
    if (clear_term)       q <= 1'b0;
    else if (rst)         q <= INIT_VAL;
    else if (preset_term) q <= 1'b1;
    else                  q <= d;
  end

  // checker-side flag: a clear was seen since the last edge
  logic clr_hit;
  always_ff @(posedge clk or posedge clear_term) begin
    if (clear_term) clr_hit <= 1'b1;
    else            clr_hit <= 1'b0;
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!preset_term && !clear_term) |=> (q == $past(d)) || clr_hit); // R1
  AST_PRESET: assert property (@(posedge clk) disable iff (rst)
    (preset_term && !clear_term) |=> q || clr_hit); // R2
  AST_CLR_HOLD: assert property (@(posedge clk)
    clr_hit |-> !q); // R3
  AST_CLR_WINS: assert property (@(posedge clk)
    (clear_term && preset_term) |=> !q || (preset_term && !clear_term && !clr_hit)); // R4
  AST_POR: assert property (@(posedge clk)
    (rst && !preset_term) |=> !q || (preset_term && !clear_term && !clr_hit)); // R10
endmodule

// File: rtl/mcell_out_path.sv
module mcell_out_path
  import mcell_pkg::*;
(
  input  mode_t mode,
  input  logic  q,
  input  logic  sum_term,
  input  logic  oe_term,
  input  logic  pin_in,
  output logic  pin_out,
  output logic  pin_oe,
  output logic  fb_out
);
  logic sel_val;

  always_comb begin
    sel_val = mode.comb ? sum_term : q;
    pin_out = mode.act_high ? sel_val : ~sel_val;
    pin_oe  = oe_term;
    fb_out  = mode.fb_pin ? pin_in : q;
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import mcell_pkg::*;
#(
  parameter int   CW       = CFG_W,
  parameter logic INIT_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg,
  input  logic          sum_term,
  input  logic          oe_term,
  input  logic          preset_term,
  input  logic          clear_term,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          fb_out
);
  mode_t mode;
  logic  q;

  mcell_cfg_decode #(.W(CW)) u_dec (
    .cfg  (cfg),
    .mode (mode)
  );

  mcell_state_reg #(.INIT_VAL(INIT_VAL)) u_reg (
    .clk         (clk),
    .rst         (rst),
    .d           (sum_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .q           (q)
  );

  mcell_out_path u_out (
    .mode     (mode),
    .q        (q),
    .sum_term (sum_term),
    .oe_term  (oe_term),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out)
  );

  AST_REG_FB: assert property (@(posedge clk)
    (cfg[CFG_FBSEL:CFG_COMB] == 2'b00) |-> fb_out == q); // R7
  AST_PIN_FB: assert property (@(posedge clk)
    (cfg[CFG_FBSEL:CFG_COMB] != 2'b00) |-> fb_out == pin_in); // R8
  AST_OE_FOLLOW: assert property (@(posedge clk)
    pin_oe == oe_term); // R9
  AST_POLARITY: assert property (@(posedge clk)
    cfg[CFG_COMB] |-> pin_out == (cfg[CFG_POL] ? sum_term : ~sum_term)); // R6
endmodule

// File: tb/tb_sop_macrocell.sv
`timescale 1ns/100ps
module tb_sop_macrocell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg = 3'b000;
  logic sum_term = 1'b0, oe_term = 1'b1, preset_term = 1'b0, clear_term = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb_out;

  always #2 clk = ~clk;

  sop_macrocell dut (
    .clk(clk), .rst(rst), .cfg(cfg), .sum_term(sum_term), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic mq = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [2:0] expect_now();
    logic sel, o, f;
    sel = cfg[1] ? sum_term : mq;
    o   = cfg[0] ? sel : ~sel;
    f   = (cfg[1] | cfg[2]) ? pin_in : mq;
    return {o, oe_term, f};
  endfunction

  task automatic apply(input logic [2:0] c, input logic s, input logic oe,
                       input logic pr, input logic cl, input logic pi,
                       input logic r, input string req);
    @(negedge clk);
    cfg = c; sum_term = s; oe_term = oe; preset_term = pr;
    clear_term = cl; pin_in = pi; rst = r;
    if (cl)      mq = 1'b0;
    else if (r)  mq = 1'b0;
    else if (pr) mq = 1'b1;
    else         mq = s;
    exp_q.push_back(expect_now());
    tag_q.push_back(req);
  endtask

  // monitor: compare one expected item shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({pin_out, pin_oe, fb_out} !== e) begin
          n_bad++;
          $display("FAIL %s: {out,oe,fb} actual %b expected %b", t,
                   {pin_out, pin_oe, fb_out}, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R10 reset state, both polarities
    apply(3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    // R1 / R7 capture, register feedback, active high
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    apply(3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    apply(3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R2 preset while sum is low
    apply(3'b001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    apply(3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    // R4 clear beats preset
    apply(3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    // R5 / R6 combinational modes, cfg[2] ignored
    apply(3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    apply(3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    apply(3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    apply(3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R8 registered output with pin feedback
    apply(3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    apply(3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // R9 disabled output, pin read back
    apply(3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    apply(3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    apply(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    // R3 clear pulse between edges: q set to one first
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    apply(3'b001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    @(posedge clk);
    #1.5;
    preset_term = 1'b0;
    clear_term  = 1'b1;
    mq = 1'b0;
    #0.5;
    n_chk++;
    if (pin_out !== 1'b0 || fb_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R3: mid-cycle {out,fb} actual %b expected 00", {pin_out, fb_out});
    end
    #0.5;
    clear_term = 1'b0;
    #0.5;
    n_chk++;
    if (pin_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R3: after pulse out actual %b expected 0", pin_out);
    end
    apply(3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    apply(3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule